// File: doc/BRIEF.md
# Shadowed Periodic Error Counter

This block tallies line error events for a DS3 receive path in a background accumulator that software cannot see. At a transfer point the accumulated count is moved into a foreground register that software reads, and the accumulator starts a fresh interval from zero. Each cycle the block may receive a parity error strobe and a framing error strobe. A source selection decides which of the two strobes count.

The transfer point depends on a mode input. In command mode it is an explicit copy strobe from software. In automatic mode it is a one-second tick. In automatic mode every tick also raises a single-cycle interrupt, which tells software that a fresh foreground value is ready. Both counters are 16 bits wide by default and stop at all-ones instead of wrapping.

Top module: `err_shadow_cnt`

## Requirements
- R1: While `rst_n` is low, `fg_count_o` is 0 and `irq_o` is 0. The background count is also cleared, so a copy issued right after reset yields 0.
- R2: With `cbit_en_i`=1 and `src_sel_i`=0, only `par_err_i` adds one to the background count. With `src_sel_i`=1, a cycle with `par_err_i` or `frm_err_i` high adds one. A cycle with both high adds exactly one.
- R3: With `cbit_en_i`=0, `src_sel_i` is ignored and only `par_err_i` is counted.
- R4: In command mode (`auto_mode_i`=0), a `copy_i` pulse at a clock edge loads the background value into `fg_count_o`, which is visible in the next cycle, and clears the background count. `tick_i` causes neither a transfer nor an interrupt.
- R5: In automatic mode (`auto_mode_i`=1), a `tick_i` pulse loads the background value into `fg_count_o` and clears the background count in the same edge. `copy_i` is ignored.
- R6: `irq_o` is high for exactly the one cycle after a `tick_i` sampled in automatic mode. This is the same cycle in which the new foreground value first appears. It is never high otherwise.
- R7: An event that arrives in a transfer cycle is not part of the transferred value. It starts the new interval, so the background count becomes 1.
- R8: The background count saturates at 2^16-1 and never wraps to 0.
- R9: `fg_count_o` changes only at a transfer. Events and ignored strobes leave it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| par_err_i | input | 1 | Parity error strobe, one event per high cycle |
| frm_err_i | input | 1 | Framing error strobe, one event per high cycle |
| cbit_en_i | input | 1 | 1 enables source selection (C-bit parity operation) |
| src_sel_i | input | 1 | 0: parity only, 1: parity or framing |
| auto_mode_i | input | 1 | 0: command transfer, 1: one-second transfer |
| copy_i | input | 1 | Copy command strobe |
| tick_i | input | 1 | One-second tick, single-cycle pulse |
| fg_count_o | output | 16 | Software-visible foreground count |
| irq_o | output | 1 | Single-cycle fresh-value interrupt |

## Verification
A counted error event and a transfer can fall in the same cycle. In that cycle the old interval must be captured without the event, and the new interval must start at one. The bench drives an event together with a copy strobe in command mode, and together with a tick in automatic mode. It then issues a second transfer with no event, which brings the hidden count out through the foreground register, so the value must come out as 1. The saturation limit and the ignored-strobe cases are judged the same way, through later transfers.

// File: rtl/err_cnt_pkg.sv
// Package: shared types and helpers for the shadowed error counter.
// Assumes: counters are unsigned and saturate at all-ones.
package err_cnt_pkg;

    // Transfer trigger selection
    typedef enum logic {
        XFER_ON_CMD  = 1'b0,
        XFER_ON_TICK = 1'b1
    } xfer_mode_e;

    // Event source selection when the selection is enabled
    typedef enum logic {
        SRC_PARITY      = 1'b0,
        SRC_PARITY_FRM  = 1'b1
    } evt_src_e;

endpackage

// File: rtl/err_evt_select.sv
// Module: picks which incoming error strobes count as one event.
// Assumes: strobes are single-cycle and synchronous to clk; both
// strobes high in one cycle form one event.
module err_evt_select
    import err_cnt_pkg::*;
(
    input  logic par_err_i,
    input  logic frm_err_i,
    input  logic cbit_en_i,
    input  logic src_sel_i,
    output logic evt_o
);

    evt_src_e src;

    // Effective source: the selection only applies with the enable set
    always_comb begin
        src = cbit_en_i ? evt_src_e'(src_sel_i) : SRC_PARITY;
    end

    // Combine the strobes according to the effective source
    always_comb begin
        case (src)
            SRC_PARITY_FRM: evt_o = par_err_i | frm_err_i;
            default:        evt_o = par_err_i;
        endcase
    end

endmodule

// File: rtl/err_xfer_ctrl.sv
// Module: decides when a transfer happens and produces the interrupt.
// Assumes: tick_i is a single-cycle pulse; the interrupt is registered,
// so it lines up with the cycle in which the foreground value changes.
module err_xfer_ctrl
    import err_cnt_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic auto_mode_i,
    input  logic copy_i,
    input  logic tick_i,
    output logic xfer_o,
    output logic irq_o
);

    xfer_mode_e mode;

    // Mode decode
    always_comb begin
        mode = xfer_mode_e'(auto_mode_i);
    end

    // Transfer trigger: copy strobe or tick, depending on the mode
    always_comb begin
        case (mode)
            XFER_ON_TICK: xfer_o = tick_i;
            default:      xfer_o = copy_i;
        endcase
    end

    // Interrupt register: one pulse after each tick taken in automatic mode
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_o <= 1'b0;
        end else begin
            irq_o <= (mode == XFER_ON_TICK) && tick_i;
        end
    end

endmodule

// File: rtl/err_bg_accum.sv
// Module: hidden background accumulator with saturation.
// Assumes: on a transfer the old value has already been taken by the
// foreground latch in the same edge; an event in that cycle opens the
// new interval.
module err_bg_accum #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             evt_i,
    input  logic             xfer_i,
    output logic [CNT_W-1:0] bg_o
);

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    logic at_max;

    // Saturation detect
    always_comb begin
        at_max = (bg_o == CNT_MAX);
    end

    // Accumulate, restart on transfer, hold at the ceiling
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bg_o <= '0;
        end else if (xfer_i) begin
            bg_o <= evt_i ? CNT_ONE : '0;
        end else if (evt_i && !at_max) begin
            bg_o <= bg_o + CNT_ONE;
        end
    end

endmodule

// File: rtl/err_fg_latch.sv
// Module: software-visible foreground register.
// Assumes: loads only on a transfer, and holds otherwise.
module err_fg_latch #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             xfer_i,
    input  logic [CNT_W-1:0] bg_i,
    output logic [CNT_W-1:0] fg_o
);

    // Capture the background value at a transfer
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fg_o <= '0;
        end else if (xfer_i) begin
            fg_o <= bg_i;
        end
    end

endmodule

// File: rtl/err_shadow_cnt.sv
// Module: top of the shadowed periodic error counter.
// Assumes: all inputs are synchronous to clk; reset is synchronous and
// active low.
module err_shadow_cnt #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             par_err_i,
    input  logic             frm_err_i,
    input  logic             cbit_en_i,
    input  logic             src_sel_i,
    input  logic             auto_mode_i,
    input  logic             copy_i,
    input  logic             tick_i,
    output logic [CNT_W-1:0] fg_count_o,
    output logic             irq_o
);

    logic             evt;
    logic             xfer;
    logic [CNT_W-1:0] bg_count;

    err_evt_select u_sel (
        .par_err_i (par_err_i),
        .frm_err_i (frm_err_i),
        .cbit_en_i (cbit_en_i),
        .src_sel_i (src_sel_i),
        .evt_o     (evt)
    );

    err_xfer_ctrl u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .auto_mode_i (auto_mode_i),
        .copy_i      (copy_i),
        .tick_i      (tick_i),
        .xfer_o      (xfer),
        .irq_o       (irq_o)
    );

    err_bg_accum #(.CNT_W(CNT_W)) u_bg (
        .clk    (clk),
        .rst_n  (rst_n),
        .evt_i  (evt),
        .xfer_i (xfer),
        .bg_o   (bg_count)
    );

    err_fg_latch #(.CNT_W(CNT_W)) u_fg (
        .clk    (clk),
        .rst_n  (rst_n),
        .xfer_i (xfer),
        .bg_i   (bg_count),
        .fg_o   (fg_count_o)
    );

endmodule

// File: rtl/err_shadow_cnt_chk.sv
// Module: property checker for err_shadow_cnt, attached by bind.
// Assumes: it sees the ports and the hidden background count.
module err_shadow_cnt_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             auto_mode_i,
    input logic             copy_i,
    input logic             tick_i,
    input logic [CNT_W-1:0] fg_count_o,
    input logic             irq_o,
    input logic [CNT_W-1:0] bg_count
);

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    // R1: reset clears every register
    assert_reset_clear_R1: assert property (@(posedge clk)
        !rst_n |=> (fg_count_o == '0 && !irq_o && bg_count == '0));

    // R4: command-mode copy moves the background value
    assert_cmd_copy_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!auto_mode_i && copy_i) |=> fg_count_o == $past(bg_count));

    // R5: automatic tick moves the background value
    assert_auto_tick_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (auto_mode_i && tick_i) |=> fg_count_o == $past(bg_count));

    // R6: interrupt follows an automatic tick
    assert_irq_on_tick_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (auto_mode_i && tick_i) |=> irq_o);

    // R6: no interrupt without an automatic tick
    assert_irq_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(auto_mode_i && tick_i) |=> !irq_o);

    // R9: foreground holds without a transfer
    assert_fg_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(auto_mode_i ? tick_i : copy_i) |=> $stable(fg_count_o));

    // R8: background count never wraps past the ceiling
    assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (bg_count == CNT_MAX && !(auto_mode_i ? tick_i : copy_i))
            |=> bg_count == CNT_MAX);

endmodule

bind err_shadow_cnt err_shadow_cnt_chk #(.CNT_W(CNT_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .auto_mode_i (auto_mode_i),
    .copy_i      (copy_i),
    .tick_i      (tick_i),
    .fg_count_o  (fg_count_o),
    .irq_o       (irq_o),
    .bg_count    (bg_count)
);

// File: tb/err_shadow_cnt_tb.sv
`timescale 1ns/1ps
module err_shadow_cnt_tb;

    localparam int CNT_W = 16;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             par_err_i = 1'b0;
    logic             frm_err_i = 1'b0;
    logic             cbit_en_i = 1'b0;
    logic             src_sel_i = 1'b0;
    logic             auto_mode_i = 1'b0;
    logic             copy_i = 1'b0;
    logic             tick_i = 1'b0;
    logic [CNT_W-1:0] fg_count_o;
    logic             irq_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    err_shadow_cnt #(.CNT_W(CNT_W)) u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .par_err_i   (par_err_i),
        .frm_err_i   (frm_err_i),
        .cbit_en_i   (cbit_en_i),
        .src_sel_i   (src_sel_i),
        .auto_mode_i (auto_mode_i),
        .copy_i      (copy_i),
        .tick_i      (tick_i),
        .fg_count_o  (fg_count_o),
        .irq_o       (irq_o)
    );

    // One row: inputs for one cycle, outputs expected after that edge
    typedef struct packed {
        logic        am;
        logic        cb;
        logic        sl;
        logic        pe;
        logic        fe;
        logic        cp;
        logic        tk;
        logic [15:0] fg;
        logic        irq;
        logic [3:0]  rq;
    } vec_t;

    localparam int NV = 18;
    localparam vec_t VEC [NV] = '{
        '{1'b0,1'b1,1'b0,1'b1,1'b0,1'b0,1'b0,16'd0,1'b0,4'd2}, // R2 parity counted, bg=1
        '{1'b0,1'b1,1'b0,1'b0,1'b1,1'b0,1'b0,16'd0,1'b0,4'd2}, // R2 framing ignored
        '{1'b0,1'b1,1'b1,1'b0,1'b1,1'b0,1'b0,16'd0,1'b0,4'd2}, // R2 framing counted, bg=2
        '{1'b0,1'b1,1'b1,1'b1,1'b1,1'b0,1'b0,16'd0,1'b0,4'd2}, // R2 both count once, bg=3
        '{1'b0,1'b0,1'b1,1'b0,1'b1,1'b0,1'b0,16'd0,1'b0,4'd3}, // R3 selection off, framing ignored
        '{1'b0,1'b0,1'b1,1'b1,1'b0,1'b0,1'b0,16'd0,1'b0,4'd3}, // R3 parity counted, bg=4
        '{1'b0,1'b1,1'b0,1'b0,1'b0,1'b1,1'b0,16'd4,1'b0,4'd4}, // R4 copy: fg=4, bg=0
        '{1'b0,1'b1,1'b0,1'b1,1'b0,1'b0,1'b1,16'd4,1'b0,4'd4}, // R4 tick ignored, bg=1
        '{1'b0,1'b1,1'b0,1'b1,1'b0,1'b1,1'b0,16'd1,1'b0,4'd7}, // R7 copy with event: fg=1, bg=1
        '{1'b0,1'b1,1'b0,1'b0,1'b0,1'b1,1'b0,16'd1,1'b0,4'd7}, // R7 new interval held 1
        '{1'b0,1'b1,1'b0,1'b1,1'b0,1'b0,1'b0,16'd1,1'b0,4'd9}, // R9 event, fg holds, bg=1
        '{1'b0,1'b1,1'b0,1'b1,1'b0,1'b0,1'b0,16'd1,1'b0,4'd9}, // R9 event, fg holds, bg=2
        '{1'b1,1'b1,1'b0,1'b0,1'b0,1'b1,1'b0,16'd1,1'b0,4'd5}, // R5 copy ignored in auto
        '{1'b1,1'b1,1'b0,1'b0,1'b0,1'b0,1'b1,16'd2,1'b1,4'd5}, // R5 tick: fg=2, irq
        '{1'b1,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,16'd2,1'b0,4'd6}, // R6 irq one cycle only
        '{1'b1,1'b1,1'b0,1'b1,1'b0,1'b0,1'b1,16'd0,1'b1,4'd7}, // R7 tick with event: fg=0, bg=1
        '{1'b1,1'b1,1'b0,1'b0,1'b0,1'b0,1'b1,16'd1,1'b1,4'd7}, // R7 back-to-back tick: fg=1
        '{1'b1,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,16'd1,1'b0,4'd6}  // R6 irq drops
    };

    task automatic check(input string req, input logic [CNT_W-1:0] exp_fg,
                         input logic exp_irq);
        n_chk++;
        if (fg_count_o !== exp_fg || irq_o !== exp_irq) begin
            n_bad++;
            $display("FAIL %s: fg=%0d irq=%0b expected fg=%0d irq=%0b",
                     req, fg_count_o, irq_o, exp_fg, exp_irq);
        end
    endtask

    task automatic idle_inputs();
        par_err_i = 1'b0; frm_err_i = 1'b0; copy_i = 1'b0; tick_i = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    endtask

    // Watchdog
    initial begin
        #(150000 * 5);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: run did not complete, expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset outputs", '0, 1'b0);
        rst_n = 1'b1;

        // Vector table
        for (int i = 0; i < NV; i++) begin
            auto_mode_i = VEC[i].am; cbit_en_i = VEC[i].cb; src_sel_i = VEC[i].sl;
            par_err_i = VEC[i].pe; frm_err_i = VEC[i].fe;
            copy_i = VEC[i].cp; tick_i = VEC[i].tk;
            @(negedge clk);
            check($sformatf("R%0d vector %0d", VEC[i].rq, i), VEC[i].fg, VEC[i].irq);
        end
        idle_inputs();

        // R8: saturation in command mode
        auto_mode_i = 1'b0; cbit_en_i = 1'b1; src_sel_i = 1'b0;
        par_err_i = 1'b1;
        repeat ((1 << CNT_W) + 4) @(negedge clk);
        check("R8 fg holds while saturating", 16'd1, 1'b0);
        par_err_i = 1'b0; copy_i = 1'b1;
        @(negedge clk);
        check("R8 saturated copy", {CNT_W{1'b1}}, 1'b0);
        @(negedge clk);
        check("R4 copy after clear", '0, 1'b0);
        copy_i = 1'b0;

        // R4: tick in command mode gives no interrupt and no transfer
        par_err_i = 1'b1;
        @(negedge clk);
        par_err_i = 1'b0; tick_i = 1'b1;
        @(negedge clk);
        tick_i = 1'b0;
        check("R4 tick ignored in command mode", '0, 1'b0);

        // R1: reset mid-run clears foreground and background
        copy_i = 1'b1;
        @(negedge clk);
        copy_i = 1'b0;
        check("R4 copy before reset", 16'd1, 1'b0);
        par_err_i = 1'b1;
        @(negedge clk);
        par_err_i = 1'b0;
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        check("R1 reset mid-run", '0, 1'b0);
        rst_n = 1'b1;
        copy_i = 1'b1;
        @(negedge clk);
        copy_i = 1'b0;
        check("R1 background cleared by reset", '0, 1'b0);

        finish_run();
    end

endmodule